// File: doc/BRIEF.md
# Timing-Monitor Margin Autocalibrator

This block tunes the delay-code setting of an on-die timing-margin monitor while the chip runs at its intended operating frequency and supply voltage. After a start request it sets the delay code to zero. It then raises the code by one delay element per step. After each change it waits a programmable number of settle cycles and then samples the monitor's error flag. The first code at which the monitor flags an error is the zero-margin point.

In a second phase the block removes a programmable guard count of delay elements from that code. This leaves a positive timing margin, so that small, frequent supply noise does not trigger the droop response. A guard of zero leaves the monitor at the exact zero-margin point.

The procedure needs no tester and finishes in a bounded number of cycles, so it can be run again whenever conditions change. Completion is marked by a one-cycle done pulse. The result is held until the next start request. Two sticky status flags report two cases. The first is a search that reached the top code without any error. The second is a guard that would have taken the code below zero.

Top module: `margin_autocal`

## Requirements
- R1: After synchronous reset, code_o, zero_code_o, done_o, busy_o, stat_sat_o and stat_uflow_o are all 0.
- R2: A start_i seen while idle sets code_o to 0, raises busy_o and clears both status flags. A start_i seen while busy has no effect on the result or on the timing of the run.
- R3: During the search code_o rises by exactly one per step. mon_err_i is sampled only after settle_i+1 cycles at each code. For a zero-margin code Z found without saturation, done_o goes high exactly (Z+1)*(settle_i+2)+1 clock edges after the edge that accepted start.
- R4: zero_code_o reports the lowest code at which mon_err_i was sampled high.
- R5: When guard_i is not above the zero-margin code Z, the final code_o is Z minus guard_i and stat_uflow_o is 0.
- R6: With guard_i equal to 0, the final code_o equals the zero-margin code.
- R7: When guard_i exceeds Z, the final code_o is clamped to 0 and stat_uflow_o is set to 1.
- R8: If no error is sampled at the top code (all ones), the run ends with code_o and zero_code_o at all ones and stat_sat_o set to 1. done_o then rises (2^CODE_W)*(settle_i+2) edges after the edge that accepted start.
- R9: done_o is high for exactly one cycle per run, and busy_o is low from that cycle on.
- R10: While idle with no start, code_o and the status outputs stay constant whatever mon_err_i does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Calibration request, taken while idle |
| settle_i | input | SETTLE_W | Extra wait cycles after each code change |
| guard_i | input | CODE_W | Delay elements removed from the zero-margin code |
| mon_err_i | input | 1 | Error flag from the timing monitor |
| code_o | output | CODE_W | Delay code driven to the monitor |
| zero_code_o | output | CODE_W | Zero-margin code found by the last run |
| done_o | output | 1 | One-cycle completion pulse |
| busy_o | output | 1 | Calibration in progress |
| stat_sat_o | output | 1 | No error found up to the top code |
| stat_uflow_o | output | 1 | Guard exceeded the zero-margin code; result clamped |

## Verification
The bench models the monitor as a threshold comparator on code_o. It aims at the following corner cases:
- A threshold of zero. A design that steps before it samples would report 1 instead.
- A threshold at the top code, and one beyond it. A design that wraps the code would go back to 0 instead of flagging saturation.
- A guard equal to the zero code, and one greater than it. A design that drops the borrow would wrap to a large code instead of clamping to 0.
- A settle of zero. An off-by-one wait would move the done cycle.

Start pulses sent in the middle of a run must leave the result and the done cycle unchanged. After done, the monitor flag is toggled to show that the held code does not move.

// File: rtl/autocal_pkg.sv
package autocal_pkg;
  typedef enum logic [1:0] {
    CAL_IDLE,
    CAL_SETTLE,
    CAL_SAMPLE,
    CAL_BACKOFF
  } cal_state_e;
endpackage

// File: rtl/autocal_settle_timer.sv
module autocal_settle_timer #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         expired_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)             cnt_q <= '0;
    else if (load_i)     cnt_q <= val_i;
    else if (cnt_q != 0) cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = (cnt_q == '0);

  // counter never reloads to a value larger than requested
  p_cnt_bound_r3: assert property (@(posedge clk) disable iff (rst)
    load_i |=> (cnt_q == $past(val_i)));
endmodule

// File: rtl/autocal_guard_sub.sv
module autocal_guard_sub #(
  parameter int W = 6
) (
  input  logic [W-1:0] zero_i,
  input  logic [W-1:0] guard_i,
  output logic [W-1:0] result_o,
  output logic         uflow_o
);
  logic [W:0] diff;

  always_comb begin
    diff     = {1'b0, zero_i} - {1'b0, guard_i};
    uflow_o  = diff[W];
    result_o = diff[W] ? '0 : diff[W-1:0];
  end
endmodule

// File: rtl/margin_autocal.sv
module margin_autocal #(
  parameter int CODE_W   = 6,
  parameter int SETTLE_W = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start_i,
  input  logic [SETTLE_W-1:0] settle_i,
  input  logic [CODE_W-1:0]   guard_i,
  input  logic                mon_err_i,
  output logic [CODE_W-1:0]   code_o,
  output logic [CODE_W-1:0]   zero_code_o,
  output logic                done_o,
  output logic                busy_o,
  output logic                stat_sat_o,
  output logic                stat_uflow_o
);
  import autocal_pkg::*;

  localparam logic [CODE_W-1:0] CODE_MAX = {CODE_W{1'b1}};

  cal_state_e          state_q;
  logic                tmr_load;
  logic                tmr_expired;
  logic [CODE_W-1:0]   sub_result;
  logic                sub_uflow;

  autocal_settle_timer #(.W(SETTLE_W)) u_timer (
    .clk       (clk),
    .rst       (rst),
    .load_i    (tmr_load),
    .val_i     (settle_i),
    .expired_o (tmr_expired)
  );

  autocal_guard_sub #(.W(CODE_W)) u_sub (
    .zero_i   (zero_code_o),
    .guard_i  (guard_i),
    .result_o (sub_result),
    .uflow_o  (sub_uflow)
  );

  always_comb begin
    tmr_load = 1'b0;
    if (state_q == CAL_IDLE && start_i) tmr_load = 1'b1;
    if (state_q == CAL_SAMPLE && !mon_err_i && code_o != CODE_MAX) tmr_load = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= CAL_IDLE;
      code_o       <= '0;
      zero_code_o  <= '0;
      done_o       <= 1'b0;
      busy_o       <= 1'b0;
      stat_sat_o   <= 1'b0;
      stat_uflow_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (state_q)
        CAL_IDLE: begin
          if (start_i) begin
            code_o       <= '0;
            busy_o       <= 1'b1;
            stat_sat_o   <= 1'b0;
            stat_uflow_o <= 1'b0;
            state_q      <= CAL_SETTLE;
          end
        end
        CAL_SETTLE: begin
          if (tmr_expired) state_q <= CAL_SAMPLE;
        end
        CAL_SAMPLE: begin
          if (mon_err_i) begin
            zero_code_o <= code_o;
            state_q     <= CAL_BACKOFF;
          end else if (code_o == CODE_MAX) begin
            zero_code_o <= CODE_MAX;
            stat_sat_o  <= 1'b1;
            done_o      <= 1'b1;
            busy_o      <= 1'b0;
            state_q     <= CAL_IDLE;
          end else begin
            code_o  <= code_o + 1'b1;
            state_q <= CAL_SETTLE;
          end
        end
        CAL_BACKOFF: begin
          code_o       <= sub_result;
          stat_uflow_o <= sub_uflow;
          done_o       <= 1'b1;
          busy_o       <= 1'b0;
          state_q      <= CAL_IDLE;
        end
        default: state_q <= CAL_IDLE;
      endcase
    end
  end

  // R9: done lasts one cycle and busy is low with it
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);
  p_done_idle_r9: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !busy_o);
  // R3: search steps by exactly one element
  p_step_one_r3: assert property (@(posedge clk) disable iff (rst)
    (state_q == CAL_SAMPLE && !mon_err_i && code_o != CODE_MAX)
      |=> (code_o == $past(code_o) + 1'b1));
  // R10: held result while idle without start
  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (state_q == CAL_IDLE && !start_i) |=> ($stable(code_o) && $stable(stat_sat_o)
      && $stable(stat_uflow_o)));
  // R7: clamped result is zero
  p_clamp_r7: assert property (@(posedge clk) disable iff (rst)
    (done_o && stat_uflow_o) |-> (code_o == '0));
  // R8: saturation leaves the top code
  p_sat_top_r8: assert property (@(posedge clk) disable iff (rst)
    (done_o && stat_sat_o) |-> (code_o == CODE_MAX && !stat_uflow_o));
  // R5: final code never above the zero-margin code
  p_below_zero_r5: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (code_o <= zero_code_o));
endmodule

// File: tb/sim_margin_autocal.sv
module sim_margin_autocal;
  localparam int CODE_W   = 6;
  localparam int SETTLE_W = 4;
  localparam int NCODES   = 1 << CODE_W;

  logic                clk = 1'b0;
  logic                rst = 1'b1;
  logic                start_i = 1'b0;
  logic [SETTLE_W-1:0] settle_i = '0;
  logic [CODE_W-1:0]   guard_i = '0;
  logic                mon_err_i;
  logic [CODE_W-1:0]   code_o, zero_code_o;
  logic                done_o, busy_o, stat_sat_o, stat_uflow_o;
  logic [CODE_W:0]     thr = '0;
  logic                force_err = 1'b0;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  assign mon_err_i = force_err | ({1'b0, code_o} >= thr);

  margin_autocal #(.CODE_W(CODE_W), .SETTLE_W(SETTLE_W)) u0 (
    .clk(clk), .rst(rst), .start_i(start_i), .settle_i(settle_i),
    .guard_i(guard_i), .mon_err_i(mon_err_i), .code_o(code_o),
    .zero_code_o(zero_code_o), .done_o(done_o), .busy_o(busy_o),
    .stat_sat_o(stat_sat_o), .stat_uflow_o(stat_uflow_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_latency(input int t, input int s);
    if (t >= NCODES) return NCODES * (s + 2);
    return (t + 1) * (s + 2) + 1;
  endfunction

  function automatic int exp_final(input int t, input int g);
    if (t >= NCODES) return NCODES - 1;
    return (g > t) ? 0 : t - g;
  endfunction

  task automatic run_cal(input int t, input int g, input int s, input bit mid);
    int n;
    int zexp;
    thr      = t[CODE_W:0];
    guard_i  = g[CODE_W-1:0];
    settle_i = s[SETTLE_W-1:0];
    start_i  = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk("R2 busy after start", busy_o, 1);
    chk("R2 code reset to 0", code_o, 0);
    n = 0;
    while (!done_o && n < 5000) begin
      @(negedge clk);
      n++;
      start_i = (mid && n == 2);
    end
    start_i = 1'b0;
    zexp = (t >= NCODES) ? NCODES - 1 : t;
    chk((t >= NCODES) ? "R8 latency" : "R3 latency", n, exp_latency(t, s));
    chk("R4 zero code", zero_code_o, zexp);
    if (t >= NCODES)      chk("R8 saturated code", code_o, exp_final(t, g));
    else if (g == 0)      chk("R6 zero guard code", code_o, exp_final(t, g));
    else if (g > t)       chk("R7 clamped code", code_o, exp_final(t, g));
    else                  chk("R5 backed-off code", code_o, exp_final(t, g));
    chk("R8 sat flag", stat_sat_o, (t >= NCODES) ? 1 : 0);
    chk("R7 uflow flag", stat_uflow_o, (t < NCODES && g > t) ? 1 : 0);
    chk("R9 busy low at done", busy_o, 0);
    @(negedge clk);
    chk("R9 done single cycle", done_o, 0);
    force_err = 1'b1;
    thr = '0;
    repeat (3) @(negedge clk);
    force_err = 1'b0;
    thr = {1'b1, {CODE_W{1'b0}}};
    repeat (2) @(negedge clk);
    chk("R10 code held", code_o, exp_final(t, g));
    chk("R10 sat held", stat_sat_o, (t >= NCODES) ? 1 : 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int seed;
    int rv;
    seed = 1234;
    rv = $urandom(seed);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 reset code", code_o, 0);
    chk("R1 reset zero code", zero_code_o, 0);
    chk("R1 reset done", done_o, 0);
    chk("R1 reset busy", busy_o, 0);
    chk("R1 reset sat", stat_sat_o, 0);
    chk("R1 reset uflow", stat_uflow_o, 0);

    run_cal(0, 0, 0, 1'b0);
    run_cal(0, 3, 2, 1'b0);
    run_cal(9, 9, 1, 1'b0);
    run_cal(9, 10, 0, 1'b1);
    run_cal(NCODES - 1, 0, 0, 1'b0);
    run_cal(NCODES - 1, 5, 15, 1'b1);
    run_cal(NCODES, 4, 0, 1'b0);
    run_cal(NCODES + 1, 0, 1, 1'b1);
    run_cal(20, 0, 3, 1'b0);

    for (int i = 0; i < 30; i++) begin
      int t, g, s;
      t = $urandom_range(NCODES + 2, 0);
      g = $urandom_range(NCODES - 1, 0);
      if ($urandom_range(1, 0) == 1) g = g % 8;
      s = $urandom_range(3, 0);
      run_cal(t, g, s, $urandom_range(1, 0) == 1);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule